// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a serial slave, framed by an active-low chip select, that lets a host write and read back a small on-chip register set. The set holds a 12-bit control word, two 12-bit offset words (channels A and B) and two 7-bit gain words (channels A and B). The serial clock, chip select and data input are first brought into the system clock domain. Falling serial-clock edges are then detected there. Each frame carries a 4-bit address and a 12-bit data word, MSB first. The shifted word is stored only on one further falling edge, the 17th.

The serial output line normally carries a parallel conversion-result word, MSB first, at the start of each frame. The top four bits of the control word form a read-select field. When that field is non-zero, the output line of later frames carries the chosen register late in the frame instead. Writing the field back to zero brings back the conversion results. The output is given as a data bit plus an output enable, and the pad tri-states the line when the enable is low.

Top module: `serreg_slave`

## Requirements
- R1: After reset the control, offset and gain registers all read zero and `douta_oe` is low.
- R2: While `cs_n` is low, each falling edge of `sclk` shifts `din` into the frame; the first 4 bits are the address and the next 12 the data, both MSB first.
- R3: The addressed register is written on the 17th falling `sclk` edge of a frame. A frame with fewer than 17 falling edges changes no register, and registers change at no other time.
- R4: Address 0001 selects control, 0010 offset A, 0011 offset B, 0100 gain A and 0101 gain B. Writes to 0000 and to 0110 through 1111 change no register.
- R5: A gain register stores the first 7 data bits after the address (data bits 11 down to 5); the last 5 data bits are not stored.
- R6: Control bits 11:8 form the read-select field. Its value is taken when `cs_n` falls and holds for that whole frame, so a control write within a frame steers only the frames after it.
- R7: With read-select 0000, the line carries the conversion word MSB first. Bit 11 is driven from the fall of `cs_n`, and bit 11-k after falling edge k for k = 1..11. The line is released after edge 12.
- R8: With read-select non-zero, the line is released until falling edge 19. It then drives bit 11-i of the selected register after edge 19+i (i = 0..11), and is released after edge 31. Codes: 0001 control, 0010/0011 offsets A/B, 0100/0101 gains A/B zero-extended to 12 bits (top 5 bits zero); any other code reads zero.
- R9: `douta_oe` is low whenever the synchronised chip select is high.
- R10: A frame with more than 17 falling edges writes its register once, with the same value a 17-edge frame would store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data input |
| conv_word | input | 12 | Conversion result sent when read-select is zero |
| douta | output | 1 | Serial output data |
| douta_oe | output | 1 | Output enable for the serial line (pad tri-states when low) |
| ctrl_reg | output | 12 | Control register |
| offs_a_reg | output | 12 | Offset register, channel A |
| offs_b_reg | output | 12 | Offset register, channel B |
| gain_a_reg | output | 7 | Gain register, channel A |
| gain_b_reg | output | 7 | Gain register, channel B |

## Verification
Some properties can be checked on every cycle, and the assertions cover these. Registers move only on the commit pulse. Unlisted addresses leave every register unchanged. A gain commit stores the top seven data bits. The edge counter steps by one per detected falling edge. The output enable drops once chip select is high. Other behaviours span whole frames and only the bench scenarios show them: the rejection of short frames, the bit order and windows on the output line, read-select being latched at frame start, and zero-extension of a gain on readback.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      SEL_CONV  = 4'h0,
      SEL_CTRL  = 4'h1,
      SEL_OFFA  = 4'h2,
      SEL_OFFB  = 4'h3,
      SEL_GAINA = 4'h4,
      SEL_GAINB = 4'h5
   } reg_sel_e;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("serreg_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q_out = stg[STAGES-1];
endmodule

// File: rtl/serreg_frame.sv
module serreg_frame #(
   parameter int SHIFT_LEN = 16,
   parameter int CNT_W     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n_s,
   input  logic                 sclk_s,
   input  logic                 din_s,
   output logic                 fall_o,
   output logic                 start_o,
   output logic                 commit_o,
   output logic                 active_o,
   output logic [CNT_W-1:0]     cnt_o,
   output logic [SHIFT_LEN-1:0] word_o
);
   if ((1 << CNT_W) <= SHIFT_LEN + 1) begin : g_bad_cnt
      $error("serreg_frame: CNT_W too small for the frame length");
   end

   localparam logic [CNT_W-1:0] CNT_MAX    = '1;
   localparam logic [CNT_W-1:0] CNT_COMMIT = CNT_W'(SHIFT_LEN);

   logic                 sclk_q;
   logic                 cs_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [SHIFT_LEN-1:0] shreg_q;

   assign fall_o   = sclk_q & ~sclk_s & ~cs_n_s;
   assign start_o  = cs_q & ~cs_n_s;
   assign active_o = ~cs_n_s;
   assign commit_o = fall_o && (cnt_q == CNT_COMMIT);
   assign cnt_o    = cnt_q;
   assign word_o   = shreg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q  <= 1'b1;
         cs_q    <= 1'b1;
         cnt_q   <= '0;
         shreg_q <= '0;
      end else begin
         sclk_q <= sclk_s;
         cs_q   <= cs_n_s;
         if (cs_n_s) begin
            cnt_q <= '0;
         end else if (fall_o && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (fall_o && cnt_q < CNT_COMMIT) begin
            shreg_q <= {shreg_q[SHIFT_LEN-2:0], din_s};
         end
      end
   end
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
   import serreg_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int GAIN_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] offs_a_q,
   output logic [DATA_W-1:0] offs_b_q,
   output logic [GAIN_W-1:0] gain_a_q,
   output logic [GAIN_W-1:0] gain_b_q,
   output logic [ADDR_W-1:0] rsel,
   output logic [DATA_W-1:0] rb_word
);
   if (GAIN_W > DATA_W) begin : g_bad_gain
      $error("serreg_bank: GAIN_W must not exceed DATA_W");
   end

   logic [DATA_W-1:0] gain_a_x;
   logic [DATA_W-1:0] gain_b_x;

   if (GAIN_W == DATA_W) begin : g_gain_full
      assign gain_a_x = gain_a_q;
      assign gain_b_x = gain_b_q;
   end else begin : g_gain_zext
      assign gain_a_x = {{(DATA_W-GAIN_W){1'b0}}, gain_a_q};
      assign gain_b_x = {{(DATA_W-GAIN_W){1'b0}}, gain_b_q};
   end

   assign rsel = ctrl_q[DATA_W-1 -: ADDR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         offs_a_q <= '0;
         offs_b_q <= '0;
         gain_a_q <= '0;
         gain_b_q <= '0;
      end else if (commit) begin
         case (addr)
            SEL_CTRL:  ctrl_q   <= data;
            SEL_OFFA:  offs_a_q <= data;
            SEL_OFFB:  offs_b_q <= data;
            SEL_GAINA: gain_a_q <= data[DATA_W-1 -: GAIN_W];
            SEL_GAINB: gain_b_q <= data[DATA_W-1 -: GAIN_W];
            default:   ;
         endcase
      end
   end

   always_comb begin
      case (rsel)
         SEL_CTRL:  rb_word = ctrl_q;
         SEL_OFFA:  rb_word = offs_a_q;
         SEL_OFFB:  rb_word = offs_b_q;
         SEL_GAINA: rb_word = gain_a_x;
         SEL_GAINB: rb_word = gain_b_x;
         default:   rb_word = '0;
      endcase
   end
endmodule

// File: rtl/serreg_dout.sv
module serreg_dout
   import serreg_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int CNT_W    = 6,
   parameter int RB_START = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [ADDR_W-1:0] rsel,
   input  logic [DATA_W-1:0] conv,
   input  logic [DATA_W-1:0] rb_word,
   output logic              dout,
   output logic              dout_oe
);
   if ((1 << CNT_W) <= RB_START + DATA_W) begin : g_bad_win
      $error("serreg_dout: CNT_W too small for the readback window");
   end

   localparam logic [CNT_W-1:0] C_DW  = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] C_RB  = CNT_W'(RB_START);
   localparam logic [CNT_W-1:0] C_RBE = CNT_W'(RB_START + DATA_W);

   logic [DATA_W-1:0] word_q;
   logic              rb_mode_q;
   logic              live_q;
   logic [CNT_W-1:0]  pos;
   logic              in_win;
   logic [DATA_W-1:0] shifted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q    <= '0;
         rb_mode_q <= 1'b0;
         live_q    <= 1'b0;
      end else if (start) begin
         word_q    <= (rsel == ADDR_W'(SEL_CONV)) ? conv : rb_word;
         rb_mode_q <= (rsel != ADDR_W'(SEL_CONV));
         live_q    <= 1'b1;
      end else if (!active) begin
         live_q    <= 1'b0;
      end
   end

   always_comb begin
      if (rb_mode_q) begin
         in_win = (cnt >= C_RB) && (cnt < C_RBE);
         pos    = cnt - C_RB;
      end else begin
         in_win = (cnt < C_DW);
         pos    = cnt;
      end
      shifted = word_q << pos;
      dout_oe = live_q & in_win;
      dout    = dout_oe & shifted[DATA_W-1];
   end
endmodule

// File: rtl/serreg_slave.sv
module serreg_slave
   import serreg_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int GAIN_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter int RB_START    = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              din,
   input  logic [DATA_W-1:0] conv_word,
   output logic              douta,
   output logic              douta_oe,
   output logic [DATA_W-1:0] ctrl_reg,
   output logic [DATA_W-1:0] offs_a_reg,
   output logic [DATA_W-1:0] offs_b_reg,
   output logic [GAIN_W-1:0] gain_a_reg,
   output logic [GAIN_W-1:0] gain_b_reg
);
   localparam int SHIFT_LEN = ADDR_W + DATA_W;
   localparam int CNT_W     = $clog2(RB_START + DATA_W + 2);

   if (DATA_W < ADDR_W) begin : g_bad_data
      $error("serreg_slave: DATA_W must hold the read-select field");
   end
   if (RB_START <= SHIFT_LEN + 1) begin : g_bad_rb
      $error("serreg_slave: readback must start after the commit edge");
   end

   logic [2:0]           sync_q;
   logic                 cs_n_s, sclk_s, din_s;
   logic                 fall, start, commit, active;
   logic [CNT_W-1:0]     cnt;
   logic [SHIFT_LEN-1:0] fword;
   logic [ADDR_W-1:0]    addr;
   logic [DATA_W-1:0]    data;
   logic [ADDR_W-1:0]    rsel;
   logic [DATA_W-1:0]    rb_word;

   serreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in({cs_n, sclk, din}), .q_out(sync_q)
   );
   assign {cs_n_s, sclk_s, din_s} = sync_q;

   serreg_frame #(.SHIFT_LEN(SHIFT_LEN), .CNT_W(CNT_W)) u_frame (
      .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .din_s(din_s),
      .fall_o(fall), .start_o(start), .commit_o(commit), .active_o(active),
      .cnt_o(cnt), .word_o(fword)
   );
   assign addr = fword[SHIFT_LEN-1 -: ADDR_W];
   assign data = fword[DATA_W-1:0];

   serreg_bank #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .commit(commit), .addr(addr), .data(data),
      .ctrl_q(ctrl_reg), .offs_a_q(offs_a_reg), .offs_b_q(offs_b_reg),
      .gain_a_q(gain_a_reg), .gain_b_q(gain_b_reg), .rsel(rsel), .rb_word(rb_word)
   );

   serreg_dout #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RB_START(RB_START)) u_dout (
      .clk(clk), .rst_n(rst_n), .start(start), .active(active), .cnt(cnt),
      .rsel(rsel), .conv(conv_word), .rb_word(rb_word),
      .dout(douta), .dout_oe(douta_oe)
   );
endmodule

// File: rtl/serreg_chk.sv
module serreg_chk #(
   parameter int DATA_W = 12,
   parameter int GAIN_W = 7,
   parameter int CNT_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n_s,
   input logic              fall,
   input logic [CNT_W-1:0]  cnt,
   input logic              commit,
   input logic [3:0]        addr,
   input logic [DATA_W-1:0] data,
   input logic [DATA_W-1:0] ctrl_reg,
   input logic [DATA_W-1:0] offs_a_reg,
   input logic [DATA_W-1:0] offs_b_reg,
   input logic [GAIN_W-1:0] gain_a_reg,
   input logic [GAIN_W-1:0] gain_b_reg,
   input logic              douta_oe
);
   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(ctrl_reg) && $stable(offs_a_reg) && $stable(offs_b_reg)
                   && $stable(gain_a_reg) && $stable(gain_b_reg)));

   p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (addr == 4'h0 || addr > 4'h5)) |=>
         ($stable(ctrl_reg) && $stable(offs_a_reg) && $stable(offs_b_reg)
          && $stable(gain_a_reg) && $stable(gain_b_reg)));

   p_gain_trunc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && addr == 4'h4) |=> (gain_a_reg == $past(data[DATA_W-1 -: GAIN_W])));

   p_oe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> !douta_oe);
endmodule

bind serreg_slave serreg_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .fall(fall), .cnt(cnt),
   .commit(commit), .addr(addr), .data(data), .ctrl_reg(ctrl_reg),
   .offs_a_reg(offs_a_reg), .offs_b_reg(offs_b_reg), .gain_a_reg(gain_a_reg),
   .gain_b_reg(gain_b_reg), .douta_oe(douta_oe)
);

// File: tb/tb_serreg_slave.sv
`timescale 1ns/1ps
module tb_serreg_slave;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b1;
   logic        din = 1'b0;
   logic [11:0] conv_word = 12'hA5C;
   logic        douta, douta_oe;
   logic [11:0] ctrl_reg, offs_a_reg, offs_b_reg;
   logic [6:0]  gain_a_reg, gain_b_reg;

   int checks = 0;
   int errors = 0;
   logic smp_d  [0:40];
   logic smp_oe [0:40];

   always #2.5 clk = ~clk;

   serreg_slave dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .conv_word(conv_word), .douta(douta), .douta_oe(douta_oe),
      .ctrl_reg(ctrl_reg), .offs_a_reg(offs_a_reg), .offs_b_reg(offs_b_reg),
      .gain_a_reg(gain_a_reg), .gain_b_reg(gain_b_reg)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // One frame: n falling edges, word = {addr, data} MSB first, zeros after bit 16
   task automatic frame(input int n, input logic [15:0] w);
      for (int i = 0; i <= 40; i++) begin smp_d[i] = 1'b0; smp_oe[i] = 1'b0; end
      @(negedge clk); cs_n = 1'b0;
      wait_clk(8);
      smp_d[0] = douta; smp_oe[0] = douta_oe;
      for (int k = 1; k <= n; k++) begin
         din = (k <= 16) ? w[16-k] : 1'b0;
         sclk = 1'b1;
         wait_clk(8);
         sclk = 1'b0;
         wait_clk(7);
         if (k <= 40) begin smp_d[k] = douta; smp_oe[k] = douta_oe; end
         wait_clk(1);
      end
      sclk = 1'b1;
      wait_clk(4);
      cs_n = 1'b1; din = 1'b0;
      wait_clk(10);
   endtask

   task automatic check_readback(input string req, input logic [11:0] exp);
      logic [11:0] got = '0;
      bit win_ok = 1'b1;
      for (int i = 0; i < 12; i++) begin
         got[11-i] = smp_d[19+i];
         if (!smp_oe[19+i]) win_ok = 1'b0;
      end
      chk(win_ok, req, 32'(win_ok), 1);
      chk(got == exp, req, 32'(got), 32'(exp));
      chk(!smp_oe[0] && !smp_oe[18] && !smp_oe[31], req,
          {29'd0, smp_oe[0], smp_oe[18], smp_oe[31]}, 0);
   endtask

   task automatic t_reset;
      chk(ctrl_reg == 0 && offs_a_reg == 0 && offs_b_reg == 0, "R1 regs12",
          {ctrl_reg, offs_a_reg[11:0], 8'd0}, 0);
      chk(gain_a_reg == 0 && gain_b_reg == 0, "R1 gains", {gain_a_reg, gain_b_reg}, 0);
      chk(!douta_oe, "R1 oe", 32'(douta_oe), 0);
   endtask

   task automatic t_writes;
      frame(17, {4'h1, 12'h03C});
      chk(ctrl_reg == 12'h03C, "R2 R4 ctrl", 32'(ctrl_reg), 32'h03C);
      frame(17, {4'h2, 12'h9B6});
      chk(offs_a_reg == 12'h9B6, "R4 offs_a", 32'(offs_a_reg), 32'h9B6);
      frame(17, {4'h3, 12'h4E1});
      chk(offs_b_reg == 12'h4E1, "R4 offs_b", 32'(offs_b_reg), 32'h4E1);
   endtask

   task automatic t_gain;
      frame(17, {4'h4, 12'hD7F});
      chk(gain_a_reg == 7'h6B, "R5 gain_a", 32'(gain_a_reg), 32'h6B);
      frame(17, {4'h5, 12'h2A0});
      chk(gain_b_reg == 7'h15, "R5 gain_b", 32'(gain_b_reg), 32'h15);
   endtask

   task automatic t_short;
      frame(16, {4'h2, 12'h123});
      chk(offs_a_reg == 12'h9B6, "R3 16 edges", 32'(offs_a_reg), 32'h9B6);
      frame(10, {4'h1, 12'hFFF});
      chk(ctrl_reg == 12'h03C, "R3 10 edges", 32'(ctrl_reg), 32'h03C);
   endtask

   task automatic t_unknown;
      frame(17, {4'h6, 12'hFFF});
      frame(17, {4'h0, 12'hFFF});
      frame(17, {4'hF, 12'hFFF});
      chk(ctrl_reg == 12'h03C && offs_a_reg == 12'h9B6 && offs_b_reg == 12'h4E1,
          "R4 ignored addr", 32'(ctrl_reg), 32'h03C);
      chk(gain_a_reg == 7'h6B && gain_b_reg == 7'h15, "R4 ignored gains",
          {gain_a_reg, gain_b_reg}, {7'h6B, 7'h15});
   endtask

   task automatic t_long;
      frame(24, {4'h3, 12'h777});
      chk(offs_b_reg == 12'h777, "R10 long frame", 32'(offs_b_reg), 32'h777);
   endtask

   task automatic t_conv;
      logic [11:0] got = '0;
      bit oe_ok = 1'b1;
      frame(32, {4'h0, 12'h000});
      for (int i = 0; i < 12; i++) begin
         got[11-i] = smp_d[i];
         if (!smp_oe[i]) oe_ok = 1'b0;
      end
      chk(oe_ok, "R7 window", 32'(oe_ok), 1);
      chk(got == conv_word, "R7 conv bits", 32'(got), 32'(conv_word));
      chk(!smp_oe[12] && !smp_oe[20], "R7 release", {smp_oe[12], smp_oe[20]}, 0);
   endtask

   task automatic t_readback;
      frame(17, {4'h1, 12'h23C});                // read-select offset A
      chk(ctrl_reg == 12'h23C, "R6 ctrl rsel", 32'(ctrl_reg), 32'h23C);
      frame(32, {4'h0, 12'h000});
      check_readback("R8 offs_a readback", 12'h9B6);
      frame(32, {4'h1, 12'h400});                // select gain A, takes effect next frame
      check_readback("R6 latched rsel", 12'h9B6);
      frame(32, {4'h1, 12'h03C});                // clear select; this frame still reads gain A
      check_readback("R8 gain zext", 12'h06B);
      frame(32, {4'h0, 12'h000});
      begin
         logic [11:0] got = '0;
         for (int i = 0; i < 12; i++) got[11-i] = smp_d[i];
         chk(got == conv_word && smp_oe[0], "R6 R7 conv restored", 32'(got), 32'(conv_word));
      end
   endtask

   task automatic t_idle;
      wait_clk(5);
      chk(!douta_oe, "R9 oe idle", 32'(douta_oe), 0);
   endtask

   initial begin
      wait_clk(5);
      t_reset();
      rst_n = 1'b1;
      wait_clk(5);
      t_reset();
      t_writes();
      t_gain();
      t_short();
      t_unknown();
      t_long();
      t_conv();
      t_readback();
      t_idle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #750000;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule